// File: doc/BRIEF.md
# Push-button wiper position controller

This block turns two active-low push buttons, one for "up" and one for "down", into a 5-bit wiper position. It is meant to drive the select lines of a 32-tap resistor ladder. Each input is synchronised and filtered. A press that stays low long enough moves the position one tap. Holding a single button keeps it stepping, first slowly and then quickly. The position stops at both ends and never wraps around.

Holding both buttons together for a long time puts the block into a shutdown state. In that state it raises a flag that disconnects the top of the ladder and parks the tap select at tap 0. The position held before shutdown is kept. A later held press on either button brings the block out of shutdown and restores that position. A two-button press whose second button arrives late is treated as a mistake: every button action is ignored until both buttons are up again.

All timing uses a millisecond strobe, divided down from the system clock by a parameter. The millisecond counts themselves are parameters too.

Top module: `pb_wiper_top`

## Requirements
- R1: A button counts as pressed only after its synchronised input has stayed low for DEB_MS (15) millisecond strobes. A low pulse shorter than that changes nothing.
- R2: A qualified press on up_ni raises the position by one, toward code 31. A qualified press on dn_ni lowers it by one, toward code 0. The step happens in the cycle the press qualifies.
- R3: The position saturates. Stepping up at 31 or down at 0 leaves it unchanged.
- R4: After reset, pos_o is 0, shdn_o is 0 and tap_o is 32'h1.
- R5: While one button stays held, another step follows every SLOW_MS (250) ms.
- R6: Once a single button has been held FAST_AFTER_MS (1000) ms after qualifying, steps repeat every FAST_MS (50) ms.
- R7: Releasing the button returns the block to idle. The next press starts again at the slow rate.
- R8: If both buttons qualify within CHORD_MS (15) ms of each other and stay held for SHDN_MS (2000) ms, shdn_o goes to 1, and pos_o and tap_o show tap 0 (tap_o = 32'h1).
- R9: In shutdown, once both buttons have been released, a qualified press on either one clears shdn_o and restores the saved position. That press causes no step. A press shorter than DEB_MS leaves the block in shutdown.
- R10: If the second button qualifies more than CHORD_MS after the first, no step, repeat or shutdown happens until both buttons are released.
- R11: A press ends only after the input has stayed high for GAP_MS (2) strobes. A shorter high glitch does not split one press into two.
- R12: tap_o is one-hot, and its only set bit is bit pos_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_ni | input | 1 | Up button, active low, asynchronous |
| dn_ni | input | 1 | Down button, active low, asynchronous |
| pos_o | output | 5 | Wiper position code |
| tap_o | output | 32 | One-hot tap select |
| shdn_o | output | 1 | Shutdown flag; disconnects the top of the ladder |

## Verification
The bench drives each button in several ways:
- Short glitches and brief presses, which separate the debounce threshold from real steps.
- Long single-button holds, sampled between step instants, which tell the slow rate from the fast rate and show saturation at 31.
- A hold after release, which shows the schedule restarts at the slow rate rather than staying fast.
- Presses split by glitches shorter and longer than GAP_MS, which show whether one press or two is counted.
- A two-button press with simultaneous arrivals, which must shut down.
- A two-button press with a late second button, which must only lock out.
- Short and qualified presses in shutdown, which show that only a qualified press restores the saved position, and does so without stepping.

// File: rtl/pb_wiper_pkg.sv
package pb_wiper_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_CHORD,
    ST_LOCK,
    ST_SD_HELD,
    ST_SD_IDLE
  } wc_state_e;
endpackage

// File: rtl/pb_ms_tick.sv
module pb_ms_tick #(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pb_btn_filter.sv
module pb_btn_filter #(
  parameter int DEB_MS = 15,
  parameter int GAP_MS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_ni,
  output logic held_o
);
  localparam int TH = (DEB_MS > GAP_MS) ? DEB_MS : GAP_MS;
  localparam int CW = $clog2(TH + 1);
  localparam logic [CW-1:0] T_DEB = CW'(DEB_MS);
  localparam logic [CW-1:0] T_GAP = CW'(GAP_MS);

  logic s1_q, s2_q, held_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;

  // two-flop synchroniser, idles high (released)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= btn_ni;
      s2_q <= s1_q;
    end
  end

  assign thr = held_q ? T_GAP : T_DEB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
    end else if ((!s2_q) == held_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q + 1'b1 >= thr) begin
        held_q <= ~held_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign held_o = held_q;

  p_qual_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_o) |-> !$past(s2_q));
  p_release_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_o) |-> $past(s2_q));
endmodule

// File: rtl/pb_wiper_ctrl.sv
module pb_wiper_ctrl
  import pb_wiper_pkg::*;
#(
  parameter int POS_W         = 5,
  parameter int SLOW_MS       = 250,
  parameter int FAST_MS       = 50,
  parameter int FAST_AFTER_MS = 1000,
  parameter int SHDN_MS       = 2000,
  parameter int CHORD_MS      = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [POS_W-1:0] pos_o,
  output logic             shdn_o
);
  localparam int HM0  = (SHDN_MS > FAST_AFTER_MS) ? SHDN_MS : FAST_AFTER_MS;
  localparam int HMAX = (HM0 > CHORD_MS) ? HM0 : CHORD_MS;
  localparam int TW   = $clog2(HMAX + 1);
  localparam int RMAX = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS;
  localparam int RW   = $clog2(RMAX + 2);
  localparam logic [TW-1:0] H_SAT = TW'(HMAX);
  localparam logic [TW-1:0] H_SD  = TW'(SHDN_MS);
  localparam logic [TW-1:0] H_FA  = TW'(FAST_AFTER_MS);
  localparam logic [TW-1:0] H_CH  = TW'(CHORD_MS);
  localparam logic [RW-1:0] R_SL  = RW'(SLOW_MS);
  localparam logic [RW-1:0] R_FS  = RW'(FAST_MS);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  wc_state_e        st_q, st_d;
  logic             dir_q, dir_d;
  logic [TW-1:0]    hold_q, hold_d, hold_inc;
  logic [RW-1:0]    rep_q, rep_d, per;
  logic [POS_W-1:0] pos_q, pos_d, save_q, save_d;
  logic             step, own, oth;

  assign hold_inc = (tick_i && hold_q != H_SAT) ? hold_q + 1'b1 : hold_q;
  assign own      = dir_q ? up_i : dn_i;
  assign oth      = dir_q ? dn_i : up_i;
  assign per      = (hold_q >= H_FA) ? R_FS : R_SL;

  always_comb begin
    st_d   = st_q;
    dir_d  = dir_q;
    hold_d = hold_inc;
    rep_d  = '0;
    save_d = save_q;
    step   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        hold_d = '0;
        if (up_i && dn_i) st_d = ST_CHORD;
        else if (up_i || dn_i) begin
          st_d  = ST_HOLD;
          dir_d = up_i;
          step  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (oth) begin
          st_d   = (hold_q <= H_CH) ? ST_CHORD : ST_LOCK;
          hold_d = '0;
        end else if (!own) begin
          st_d = ST_IDLE;
        end else if (tick_i) begin
          if (rep_q + 1'b1 >= per) step = 1'b1;
          else rep_d = rep_q + 1'b1;
        end else begin
          rep_d = rep_q;
        end
      end
      ST_CHORD: begin
        if (!up_i || !dn_i) st_d = ST_LOCK;
        else if (tick_i && hold_q + 1'b1 >= H_SD) begin
          st_d   = ST_SD_HELD;
          save_d = pos_q;
        end
      end
      ST_SD_HELD: if (!up_i && !dn_i) st_d = ST_SD_IDLE;
      ST_SD_IDLE: if (up_i || dn_i) st_d = ST_LOCK;
      ST_LOCK:    if (!up_i && !dn_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pos_d = pos_q;
    if (st_q == ST_CHORD && st_d == ST_SD_HELD) pos_d = '0;
    else if (st_q == ST_SD_IDLE && st_d == ST_LOCK) pos_d = save_q;
    else if (step) begin
      if (dir_d && pos_q != POS_MAX) pos_d = pos_q + 1'b1;
      else if (!dir_d && pos_q != '0) pos_d = pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      hold_q <= '0;
      rep_q  <= '0;
      pos_q  <= '0;
      save_q <= '0;
    end else begin
      st_q   <= st_d;
      dir_q  <= dir_d;
      hold_q <= hold_d;
      rep_q  <= rep_d;
      pos_q  <= pos_d;
      save_q <= save_d;
    end
  end

  assign pos_o  = pos_q;
  assign shdn_o = (st_q == ST_SD_HELD) || (st_q == ST_SD_IDLE);

  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_HOLD) |=>
      (pos_q == $past(pos_q) || pos_q == $past(pos_q) + 1'b1 || pos_q + 1'b1 == $past(pos_q)));
  p_shdn_tap0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_o |-> pos_q == '0);
  p_lock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_LOCK |=> pos_q == $past(pos_q));
  p_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SD_IDLE && (up_i || dn_i)) |=> (pos_q == $past(save_q) && !shdn_o));
endmodule

// File: rtl/pb_wiper_top.sv
module pb_wiper_top #(
  parameter int CLKS_PER_MS   = 50000,
  parameter int POS_W         = 5,
  parameter int DEB_MS        = 15,
  parameter int GAP_MS        = 2,
  parameter int SLOW_MS       = 250,
  parameter int FAST_MS       = 50,
  parameter int FAST_AFTER_MS = 1000,
  parameter int SHDN_MS       = 2000,
  parameter int CHORD_MS      = 15,
  localparam int NTAP         = 1 << POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_ni,
  input  logic             dn_ni,
  output logic [POS_W-1:0] pos_o,
  output logic [NTAP-1:0]  tap_o,
  output logic             shdn_o
);
  logic       tick;
  logic [1:0] btn_n, held;

  assign btn_n = {dn_ni, up_ni};

  pb_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar g = 0; g < 2; g++) begin : g_btn
    pb_btn_filter #(.DEB_MS(DEB_MS), .GAP_MS(GAP_MS)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .btn_ni(btn_n[g]),
      .held_o(held[g])
    );
  end

  pb_wiper_ctrl #(
    .POS_W(POS_W), .SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS),
    .FAST_AFTER_MS(FAST_AFTER_MS), .SHDN_MS(SHDN_MS), .CHORD_MS(CHORD_MS)
  ) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .up_i  (held[0]),
    .dn_i  (held[1]),
    .pos_o (pos_o),
    .shdn_o(shdn_o)
  );

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tap_o[i] = (pos_o == POS_W'(i));
  end

  p_tap_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(tap_o) && tap_o[pos_o]);
endmodule

// File: tb/pb_wiper_top_test.sv
module pb_wiper_top_test;
  localparam int CPM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_n = 1'b1;
  logic        dn_n = 1'b1;
  logic [4:0]  pos;
  logic [31:0] tap;
  logic        shdn;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pb_wiper_top #(.CLKS_PER_MS(CPM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .up_ni(up_n), .dn_ni(dn_n),
    .pos_o(pos), .tap_o(tap), .shdn_o(shdn)
  );

  task automatic wait_ms(input int ms);
    repeat (ms * CPM) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // position, one-hot tap (R12) and flag together
  task automatic chk_state(input string req, input int exp_pos, input int exp_sd);
    chk(req, int'(pos), exp_pos);
    chk({req, " R12 tap"}, int'(tap == (32'h1 << exp_pos)), 1);
    chk({req, " shdn"}, int'(shdn), exp_sd);
  endtask

  task automatic press(input bit u, input bit d, input int ms);
    @(negedge clk);
    up_n = ~u; dn_n = ~d;
    wait_ms(ms);
    up_n = 1'b1; dn_n = 1'b1;
    wait_ms(20);
  endtask

  task automatic t_reset();
    chk_state("R4 reset", 0, 0);
  endtask

  task automatic t_debounce();
    press(1, 0, 8);
    chk_state("R1 short pulse", 0, 0);
    @(negedge clk); up_n = 1'b0;
    wait_ms(10);
    chk_state("R1 before debounce", 0, 0);
    wait_ms(20);
    chk_state("R2 up step", 1, 0);
    wait_ms(30);
    up_n = 1'b1; wait_ms(20);
    press(0, 1, 60);
    chk_state("R2 down step", 0, 0);
    press(0, 1, 60);
    chk_state("R3 floor", 0, 0);
  endtask

  task automatic t_repeat();
    @(negedge clk); up_n = 1'b0;
    wait_ms(140);  chk_state("R5 first slow", 1, 0);
    wait_ms(250);  chk_state("R5 slow repeat", 2, 0);
    wait_ms(1150); chk_state("R6 fast repeat", 15, 0);
    wait_ms(1060); chk_state("R3 ceiling", 31, 0);
    up_n = 1'b1; wait_ms(20);
    @(negedge clk); dn_n = 1'b0;
    wait_ms(140);  chk_state("R7 new press", 30, 0);
    wait_ms(250);  chk_state("R7 slow again", 29, 0);
    dn_n = 1'b1; wait_ms(20);
  endtask

  task automatic t_gap();
    @(negedge clk); up_n = 1'b0;
    wait_ms(100); up_n = 1'b1;
    wait_ms(1);   up_n = 1'b0;
    wait_ms(100); up_n = 1'b1;
    wait_ms(20);
    chk_state("R11 glitch one press", 30, 0);
    @(negedge clk); dn_n = 1'b0;
    wait_ms(100); dn_n = 1'b1;
    wait_ms(10);  dn_n = 1'b0;
    wait_ms(100); dn_n = 1'b1;
    wait_ms(20);
    chk_state("R11 real gap two presses", 28, 0);
  endtask

  task automatic t_late_chord();
    @(negedge clk); up_n = 1'b0;
    wait_ms(100); dn_n = 1'b0;
    wait_ms(1000); chk_state("R10 no repeat", 29, 0);
    wait_ms(1500); chk_state("R10 no shutdown", 29, 0);
    up_n = 1'b1; dn_n = 1'b1; wait_ms(20);
    press(0, 1, 60);
    chk_state("R10 unlocked", 28, 0);
  endtask

  task automatic t_shutdown();
    @(negedge clk); up_n = 1'b0; dn_n = 1'b0;
    wait_ms(1900); chk_state("R8 before hold time", 28, 0);
    wait_ms(200);  chk_state("R8 shutdown", 0, 1);
    up_n = 1'b1; dn_n = 1'b1; wait_ms(20);
    chk_state("R8 stays after release", 0, 1);
    press(1, 0, 8);
    chk_state("R9 short press ignored", 0, 1);
    @(negedge clk); dn_n = 1'b0;
    wait_ms(100);  chk_state("R9 restored no step", 28, 0);
    dn_n = 1'b1; wait_ms(20);
    press(1, 0, 60);
    chk_state("R9 normal after exit", 29, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_ms(5);
    t_reset();
    t_debounce();
    t_repeat();
    t_gap();
    t_late_chord();
    t_shutdown();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule